// File: doc/BRIEF.md
# Serial Code Word Detector with Data Capture

This block watches a serial receive stream, one bit per enabled clock, and looks for a programmable code word at every bit position. The code word is the same word the transmit side sends, and its length is 16 or 24 bits. When the most recent bits equal the code word, the block takes in the word that follows. That word has the same length as the code word. At the clock edge that accepts its last bit, the block moves the word into a holding register that a host can read and raises a status flag.

While it takes in the following word, the block does not look for the code word. Searching starts again once the capture is complete, with an empty window. The status flag stays high until the host acknowledges it. A later capture replaces the held word.

Top module: `cwd_top`

## Requirements
- R1: The block accepts a bit from `rx_bit` only on a clock edge where `rx_bit_en` is 1. With `rx_bit_en` at 0, changes on `rx_bit` have no effect on detection or capture.
- R2: The length is 16 bits when `len_long` is 0, and the comparison then uses only `code_word[15:0]`. The length is 24 bits when `len_long` is 1, and the comparison uses all of `code_word`. Bits reach the window oldest first, so the first bit received lines up with the code word's most significant compared bit.
- R3: The comparison runs on every accepted bit. A code word is found at any alignment, whatever bits come before it in the stream.
- R4: After a detection, the next L accepted bits (L = 16 or 24) are captured. The first captured bit lands in `rx_word` bit L-1. For L = 16, `rx_word[23:16]` reads 0.
- R5: No detection happens while a capture is in progress. After a capture ends, L new bits must be accepted before the next detection, so bits received before or during the capture never count toward a match.
- R6: `rx_word` and `rx_valid` update at the clock edge that accepts the last captured bit. Before that edge, `rx_valid` stays 0.
- R7: `rx_valid` stays 1 and `rx_word` stays unchanged until `host_ack` is 1 on a clock edge. That edge clears `rx_valid` and leaves `rx_word` as it was.
- R8: A new capture overwrites `rx_word`. If a capture completes on the same edge as `host_ack`, `rx_valid` stays 1 and `rx_word` holds the new word.
- R9: The length is fixed at the moment of detection. A change on `len_long` during a capture has no effect on that capture.
- R10: While `rst_n` is 0 at a clock edge, `rx_valid` and `rx_word` go to 0, any capture is abandoned, and the window is emptied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_bit | input | 1 | Serial receive data, most significant bit first |
| rx_bit_en | input | 1 | Accept `rx_bit` on this edge |
| code_word | input | 24 | Code word to search for |
| len_long | input | 1 | Length select: 0 for 16 bits, 1 for 24 bits |
| host_ack | input | 1 | Host acknowledge, clears the status flag |
| rx_word | output | 24 | Last captured word |
| rx_valid | output | 1 | Status: a captured word is waiting for the host |

## Verification
Two functions can act on the status flag in the same cycle: a capture finishing, which sets it, and the host acknowledge, which clears it. The bench holds one word unacknowledged, runs a second code word and data word through the block, and asserts `host_ack` on the very edge that carries the last data bit. It then expects the flag still set with the second word in the register, and expects a later acknowledge on its own to clear the flag without changing the word.

// File: rtl/cwd_pkg.sv
// Package cwd_pkg
// Shared definitions for the code word detector: the default word lengths,
// the capture state type and a helper that forms the length-dependent mask.
// Assumes the long length is at least the short length.
package cwd_pkg;

    parameter int CWD_LONG_W  = 24;
    parameter int CWD_SHORT_W = 16;

    typedef enum logic {
        CWD_SEARCH  = 1'b0,
        CWD_CAPTURE = 1'b1
    } cwd_state_e;

    // Mask of the low bits in use, as a 64-bit value the caller truncates.
    function automatic logic [63:0] cwd_len_mask(input logic long_sel,
                                                 input int   long_w,
                                                 input int   short_w);
        int n;
        n = long_sel ? long_w : short_w;
        return (64'd1 << n) - 64'd1;
    endfunction

endpackage

// File: rtl/cwd_window.sv
// Module cwd_window
// Keeps the recent received bits and flags a code word match on the edge
// that accepts the last bit of the code word. A fill counter is cleared
// whenever searching is paused, so only bits that arrive while searching
// count toward a match. Assumes search_en is driven low by the capture logic
// for the whole of a capture.
module cwd_window
    import cwd_pkg::*;
#(
    parameter int LONG_W  = CWD_LONG_W,
    parameter int SHORT_W = CWD_SHORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_bit,
    input  logic              rx_bit_en,
    input  logic              search_en,
    input  logic              len_long,
    input  logic [LONG_W-1:0] code_word,
    output logic              hit
);
    localparam int CNT_W = $clog2(LONG_W + 1);

    logic [LONG_W-1:0] hist_q;
    logic [CNT_W-1:0]  fill_q;
    logic [LONG_W-1:0] cand;
    logic [LONG_W-1:0] mask;
    logic [CNT_W-1:0]  need;

    // Shift each accepted bit into the window history.
    always_ff @(posedge clk) begin
        if (!rst_n)         hist_q <= '0;
        else if (rx_bit_en) hist_q <= {hist_q[LONG_W-2:0], rx_bit};
    end

    // Count bits received since searching (re)started, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !search_en)
            fill_q <= '0;
        else if (rx_bit_en && fill_q != CNT_W'(LONG_W))
            fill_q <= fill_q + 1'b1;
    end

    // Compare the window including the incoming bit against the code word.
    always_comb begin
        cand = {hist_q[LONG_W-2:0], rx_bit};
        mask = LONG_W'(cwd_len_mask(len_long, LONG_W, SHORT_W));
        need = len_long ? CNT_W'(LONG_W - 1) : CNT_W'(SHORT_W - 1);
        hit  = search_en && rx_bit_en && (fill_q >= need)
               && (((cand ^ code_word) & mask) == '0);
    end

    // R5: a pause in searching always leaves an empty window behind it.
    assert_fill_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !search_en |=> (fill_q == '0));

    // R1: without a bit enable the history does not move.
    assert_hist_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_bit_en |=> $stable(hist_q));

endmodule

// File: rtl/cwd_capture.sv
// Module cwd_capture
// After a start pulse, collects the next L accepted bits, L being fixed by
// the length select at the start. Signals completion combinationally on the
// edge that accepts the final bit, with the finished word alongside.
// Assumes start arrives only while idle.
module cwd_capture
    import cwd_pkg::*;
#(
    parameter int LONG_W  = CWD_LONG_W,
    parameter int SHORT_W = CWD_SHORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_bit,
    input  logic              rx_bit_en,
    input  logic              start,
    input  logic              len_long,
    output logic              busy,
    output logic              done,
    output logic [LONG_W-1:0] word
);
    localparam int CNT_W = $clog2(LONG_W + 1);

    cwd_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [LONG_W-1:0] sh_q;
    logic              long_q;
    logic [CNT_W-1:0]  last_idx;

    // Decode the final bit position and the finished word.
    always_comb begin
        last_idx = long_q ? CNT_W'(LONG_W - 1) : CNT_W'(SHORT_W - 1);
        busy     = (state_q == CWD_CAPTURE);
        done     = busy && rx_bit_en && (cnt_q == last_idx);
        word     = {sh_q[LONG_W-2:0], rx_bit}
                   & LONG_W'(cwd_len_mask(long_q, LONG_W, SHORT_W));
    end

    // Sequence the capture: latch the length, count and shift the bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CWD_SEARCH;
            cnt_q   <= '0;
            sh_q    <= '0;
            long_q  <= 1'b0;
        end else if (state_q == CWD_SEARCH) begin
            if (start) begin
                state_q <= CWD_CAPTURE;
                cnt_q   <= '0;
                long_q  <= len_long;
            end
        end else if (rx_bit_en) begin
            sh_q  <= {sh_q[LONG_W-2:0], rx_bit};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == last_idx) state_q <= CWD_SEARCH;
        end
    end

    // R1: idle bit slots leave the capture untouched.
    assert_hold_without_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rx_bit_en) |=> ($stable(sh_q) && $stable(cnt_q) && busy));

    // R9: the latched length cannot change during a capture.
    assert_len_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(long_q));

endmodule

// File: rtl/cwd_holdreg.sv
// Module cwd_holdreg
// Host-facing holding register and status flag. A load stores the word and
// sets the flag; an acknowledge clears the flag unless a load happens on
// the same edge, in which case the load wins.
module cwd_holdreg #(
    parameter int LONG_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LONG_W-1:0] load_word,
    input  logic              ack,
    output logic [LONG_W-1:0] word,
    output logic              valid
);
    // Store the captured word.
    always_ff @(posedge clk) begin
        if (!rst_n)    word <= '0;
        else if (load) word <= load_word;
    end

    // Status flag: set on load, cleared by acknowledge, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)    valid <= 1'b0;
        else if (load) valid <= 1'b1;
        else if (ack)  valid <= 1'b0;
    end

    // R6 and R8: a load always leaves the new word visible with the flag set.
    assert_status_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (valid && word == $past(load_word)));

    // R7: without load or acknowledge, flag and word hold.
    assert_status_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ack && !load) |=> (valid && $stable(word)));

endmodule

// File: rtl/cwd_top.sv
// Module cwd_top
// Code word detector with data capture. The window module searches the
// serial stream for the code word; a match starts the capture module, which
// collects the following word and loads it into the host holding register.
// Searching is paused for the duration of each capture.
module cwd_top
    import cwd_pkg::*;
#(
    parameter int LONG_W  = CWD_LONG_W,
    parameter int SHORT_W = CWD_SHORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_bit,
    input  logic              rx_bit_en,
    input  logic [LONG_W-1:0] code_word,
    input  logic              len_long,
    input  logic              host_ack,
    output logic [LONG_W-1:0] rx_word,
    output logic              rx_valid
);
    logic              hit;
    logic              cap_busy;
    logic              cap_done;
    logic [LONG_W-1:0] cap_word;

    cwd_window #(.LONG_W(LONG_W), .SHORT_W(SHORT_W)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_bit    (rx_bit),
        .rx_bit_en (rx_bit_en),
        .search_en (!cap_busy),
        .len_long  (len_long),
        .code_word (code_word),
        .hit       (hit)
    );

    cwd_capture #(.LONG_W(LONG_W), .SHORT_W(SHORT_W)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_bit    (rx_bit),
        .rx_bit_en (rx_bit_en),
        .start     (hit),
        .len_long  (len_long),
        .busy      (cap_busy),
        .done      (cap_done),
        .word      (cap_word)
    );

    cwd_holdreg #(.LONG_W(LONG_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cap_done),
        .load_word (cap_word),
        .ack       (host_ack),
        .word      (rx_word),
        .valid     (rx_valid)
    );

    // R4: every detection hands over to a capture on the next cycle.
    assert_hit_starts_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> cap_busy);

    // R5: no detection is reported while a capture runs.
    assert_no_hit_in_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_busy |-> !hit);

endmodule

// File: tb/cwd_top_test.sv
module cwd_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_bit = 1'b0;
    logic        rx_bit_en = 1'b0;
    logic [23:0] code_word = '0;
    logic        len_long = 1'b0;
    logic        host_ack = 1'b0;
    logic [23:0] rx_word;
    logic        rx_valid;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit finished = 1'b0;

    // 125 MHz clock.
    always #4 clk = ~clk;

    cwd_top uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_bit    (rx_bit),
        .rx_bit_en (rx_bit_en),
        .code_word (code_word),
        .len_long  (len_long),
        .host_ack  (host_ack),
        .rx_word   (rx_word),
        .rx_valid  (rx_valid)
    );

    // Vector layout: [56] length select, [55:32] code word, [31:24] 8-bit
    // prefix, [23:0] data word sent after the code word.
    localparam logic [56:0] VEC [4] = '{
        {1'b0, 24'h77B38E, 8'h00, 24'h001234},
        {1'b1, 24'hC5A3F1, 8'hFF, 24'hABCDEF},
        {1'b0, 24'h006D2B, 8'h5A, 24'h00FFFF},
        {1'b1, 24'h0F1E2D, 8'hA5, 24'h6D2B00}
    };

    task automatic check(input bit ok, input string req,
                         input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input bit ack = 1'b0);
        @(negedge clk);
        rx_bit = b; rx_bit_en = 1'b1; host_ack = ack;
        @(posedge clk);
        @(negedge clk);
        rx_bit_en = 1'b0; host_ack = 1'b0;
    endtask

    task automatic send_bits(input logic [23:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic ack_host();
        @(negedge clk);
        host_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        host_ack = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_bit = ~rx_bit;
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
            finish_run();
        end
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        check(rx_valid == 1'b0, "R10 valid in reset", {23'd0, rx_valid}, 24'd0);
        check(rx_word == 24'd0, "R10 word in reset", rx_word, 24'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: R2, R3, R4, R6, R7
        for (int v = 0; v < 4; v++) begin
            logic        lg;
            logic [23:0] cw, dw, exp;
            int          n;
            lg  = VEC[v][56];
            cw  = VEC[v][55:32];
            dw  = VEC[v][23:0];
            n   = lg ? 24 : 16;
            exp = lg ? dw : (dw & 24'h00FFFF);
            len_long  = lg;
            code_word = cw;
            send_bits({16'd0, VEC[v][31:24]}, 8);
            send_bits(cw, n);
            send_bits(dw >> 1, n - 1);
            check(rx_valid == 1'b0, "R6 valid before last bit", {23'd0, rx_valid}, 24'd0);
            send_bit(dw[0]);
            check(rx_valid == 1'b1, "R3 detect after prefix", {23'd0, rx_valid}, 24'd1);
            check(rx_word == exp, "R4 captured word", rx_word, exp);
            ack_host();
            check(rx_valid == 1'b0 && rx_word == exp, "R7 ack clears flag only",
                  rx_word, exp);
        end

        // R1: bit slots without enable are ignored
        len_long  = 1'b0;
        code_word = 24'h00B38E;
        send_bits(24'h00B38E >> 1, 15);
        idle(6);
        send_bit(1'b0);
        send_bits(24'h00C0DE, 16);
        check(rx_valid == 1'b1 && rx_word == 24'h00C0DE, "R1 gaps ignored",
              rx_word, 24'h00C0DE);

        // R7: flag and word hold without acknowledge
        idle(10);
        check(rx_valid == 1'b1 && rx_word == 24'h00C0DE, "R7 flag sticky",
              rx_word, 24'h00C0DE);
        ack_host();

        // R5: code word completed across the captured data does not match
        send_bits(24'h00B38E, 16);
        send_bits(24'h0012B3, 16);
        check(rx_word == 24'h0012B3, "R5 data equal capture", rx_word, 24'h0012B3);
        ack_host();
        send_bits(24'h00008E, 8);
        send_bits(24'h005555, 16);
        check(rx_valid == 1'b0, "R5 no match across capture", {23'd0, rx_valid}, 24'd0);

        // R8: capture completion and acknowledge on the same edge
        send_bits(24'h00B38E, 16);
        send_bits(24'h001111, 16);
        check(rx_word == 24'h001111, "R8 first word", rx_word, 24'h001111);
        send_bits(24'h00B38E, 16);
        send_bits(24'h002222 >> 1, 15);
        send_bit(1'b0, 1'b1);
        check(rx_valid == 1'b1, "R8 set wins over ack", {23'd0, rx_valid}, 24'd1);
        check(rx_word == 24'h002222, "R8 overwrite", rx_word, 24'h002222);
        ack_host();
        check(rx_valid == 1'b0 && rx_word == 24'h002222, "R7 ack after overwrite",
              rx_word, 24'h002222);

        // R9: length change during capture has no effect
        send_bits(24'h00B38E, 16);
        len_long = 1'b1;
        send_bits(24'h004A4A, 16);
        check(rx_valid == 1'b1 && rx_word == 24'h004A4A, "R9 length latched",
              rx_word, 24'h004A4A);
        len_long = 1'b0;
        ack_host();

        // R10: reset in the middle of a capture
        send_bits(24'h00B38E, 16);
        send_bits(24'h0000FF, 8);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        send_bits(24'h0000FF, 8);
        check(rx_valid == 1'b0 && rx_word == 24'd0, "R10 reset abandons capture",
              rx_word, 24'd0);

        finish_run();
    end

endmodule